// File: doc/BRIEF.md
# Triggered One-Pulse PWM Timer

A single-channel up-counter that waits for a rising edge on a trigger input and then produces one delayed pulse on its reference output. The compare value sets how many counts pass before the pulse begins. The auto-reload value sets where the count wraps. In one-shot operation the counter stops itself at the wrap, so the pulse width is the reload value minus the compare value. With one-shot operation off, the same start gives a free-running PWM waveform.

Compare and reload values can be written straight into the active registers, or held in shadow copies that take effect only at the next update event. A fast-start option drives the reference to its match level at the trigger, without waiting for the count to reach the compare value. A level-sensitive external clear forces the reference low until the following update event. A polarity bit picks whether the waveform pin carries the reference as is or inverted.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset the count is 0, `running` is 0, and with `oc_mode` = 3'b111 `ref_out` is 0.
- R2: A rising trigger edge (`trig_in` high, low in the previous cycle) while stopped sets `running` at the next clock. From then on the count advances by one per clock, starting from its held value. While stopped and with no software update, the count holds.
- R3: While running, a count equal to the active reload value is followed by count 0, which is an update event. When `one_pulse` is 1, `running` clears at that same clock.
- R4: With `oc_mode` = 3'b111 the reference is 1 when the count is at least the compare value and not equal to the reload value, and 0 otherwise. With `oc_mode` = 3'b110 the reference is 1 exactly when the count is below the compare value.
- R5: With `oc_mode` 3'b111, one-shot mode, compare C and reload A (0 < C < A), a trigger from count 0 gives a reference that rises C clocks after `running` rises and stays high for A−C clocks. `running` stays high for A+1 clocks.
- R6: A trigger edge that arrives while running has no effect on the count, on `running` or on the pulse.
- R7: If `fast_en` is 1 at the start and `oc_mode` is 3'b110 or 3'b111, the reference takes its match level (1 for 3'b111 except at the reload count, 0 for 3'b110) from the first running cycle until the next update event.
- R8: With `clr_en` = 1 and a non-forced mode, `ext_clr` sampled high makes the reference 0 from the next clock. It stays 0 until the next update event, even after `ext_clr` falls.
- R9: `oc_mode` 3'b100 makes the reference 0 and 3'b101 makes it 1, whatever the count, and the external clear has no effect in those modes. Any other encoding outside 3'b110 and 3'b111 gives a reference of 0.
- R10: With a preload enable set, writes to that register (compare or reload) go to a shadow copy, and the active value changes only at an update event. With the enable clear, a write changes the active value at the next clock.
- R11: `sw_update` high produces an update event: the count becomes 0, the shadow copies are moved to the active registers, and in one-shot mode `running` clears.
- R12: `wave_out` equals `ref_out` when `out_pol` is 0 and its inverse when `out_pol` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Trigger; a rising edge starts a stopped counter |
| ext_clr | input | 1 | External clear level for the reference |
| oc_mode | input | 3 | Output mode: 100 low, 101 high, 110 PWM1, 111 PWM2 |
| one_pulse | input | 1 | Stop the counter at the next update event |
| fast_en | input | 1 | Force the match level at the trigger |
| clr_en | input | 1 | Enables the external clear |
| cmp_pre_en | input | 1 | Compare writes go to the shadow copy |
| arr_pre_en | input | 1 | Reload writes go to the shadow copy |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write value |
| arr_we | input | 1 | Reload write strobe |
| arr_wdata | input | W | Reload write value |
| sw_update | input | 1 | Software-requested update event |
| out_pol | input | 1 | 1 inverts the waveform output |
| cnt_out | output | W | Current count |
| running | output | 1 | Counter enabled |
| ref_out | output | 1 | Reference waveform |
| wave_out | output | 1 | Reference after polarity selection |

## Verification
The main function is driven by single triggers in one-shot mode and compared with a behavioural model on every clock. The delay, width and run length of each pulse are also measured. A second edge placed mid-pulse shows whether a running counter is wrongly restarted. A free-running sequence across several wraps separates stop-at-update from plain wrapping. Fast start, a clear pulse that ends early, forced modes with the clear held high, and shadowed writes followed by either a natural wrap or a software update each single out one override path, and one preload path per register.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

    typedef enum logic [2:0] {
        MODE_FRZ   = 3'b000,
        MODE_FLOW  = 3'b100,
        MODE_FHIGH = 3'b101,
        MODE_PWM1  = 3'b110,
        MODE_PWM2  = 3'b111
    } tpt_mode_e;

    // override flags held by the reference generator
    typedef struct packed {
        logic fast;
        logic clr;
    } tpt_ovr_t;

    localparam int NUM_SHADOW = 2;
    localparam int IDX_CMP    = 0;
    localparam int IDX_ARR    = 1;

    function automatic logic is_forced(input logic [2:0] m);
        return (m == MODE_FLOW) || (m == MODE_FHIGH);
    endfunction

    function automatic logic is_pwm(input logic [2:0] m);
        return (m == MODE_PWM1) || (m == MODE_PWM2);
    endfunction

endpackage

// File: rtl/tpt_count_ctrl.sv
module tpt_count_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_in,
    input  logic         one_pulse,
    input  logic         sw_update,
    input  logic [W-1:0] arr_act,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         start,
    output logic         uev
);
    logic trig_q;
    logic trig_rise;
    logic at_top;

    assign trig_rise = trig_in & ~trig_q;
    assign start     = trig_rise & ~run;
    assign at_top    = run && (cnt == arr_act);
    assign uev       = sw_update | at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            cnt    <= '0;
            run    <= 1'b0;
        end else begin
            trig_q <= trig_in;
            if (uev)
                cnt <= '0;
            else if (run)
                cnt <= cnt + 1'b1;
            if (start)
                run <= 1'b1;
            else if (uev && one_pulse)
                run <= 1'b0;
        end
    end
endmodule

// File: rtl/tpt_preload_reg.sv
module tpt_preload_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         pre_en,
    input  logic         uev,
    output logic [W-1:0] act
);
    logic [W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            act    <= '0;
        end else begin
            if (we)
                shadow <= wdata;
            if (we && !pre_en)
                act <= wdata;
            else if (uev)
                act <= shadow;
        end
    end
endmodule

// File: rtl/tpt_ref_gen.sv
module tpt_ref_gen
    import tpt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] arr,
    input  logic         start,
    input  logic         uev,
    input  logic         fast_en,
    input  logic         clr_en,
    input  logic         ext_clr,
    output logic         ref_o
);
    tpt_ovr_t ovr;
    logic     raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= '0;
        end else begin
            if (start && fast_en && is_pwm(mode))
                ovr.fast <= 1'b1;
            else if (uev)
                ovr.fast <= 1'b0;
            if (clr_en && ext_clr && !is_forced(mode))
                ovr.clr <= 1'b1;
            else if (uev)
                ovr.clr <= 1'b0;
        end
    end

    always_comb begin
        case (mode)
            MODE_FLOW:  raw = 1'b0;
            MODE_FHIGH: raw = 1'b1;
            MODE_PWM1:  raw = ovr.fast ? 1'b0 : (cnt < cmp);
            MODE_PWM2:  raw = ovr.fast ? (cnt != arr)
                                       : ((cnt >= cmp) && (cnt != arr));
            default:    raw = 1'b0;
        endcase
        ref_o = (ovr.clr && !is_forced(mode)) ? 1'b0 : raw;
    end
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
    import tpt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_in,
    input  logic         ext_clr,
    input  logic [2:0]   oc_mode,
    input  logic         one_pulse,
    input  logic         fast_en,
    input  logic         clr_en,
    input  logic         cmp_pre_en,
    input  logic         arr_pre_en,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         arr_we,
    input  logic [W-1:0] arr_wdata,
    input  logic         sw_update,
    input  logic         out_pol,
    output logic [W-1:0] cnt_out,
    output logic         running,
    output logic         ref_out,
    output logic         wave_out
);
    logic                  start;
    logic                  uev;
    logic [W-1:0]          cmp_act;
    logic [W-1:0]          arr_act;
    logic [NUM_SHADOW-1:0] we_v;
    logic [NUM_SHADOW-1:0] pre_v;
    logic [W-1:0]          wd_v  [NUM_SHADOW];
    logic [W-1:0]          act_v [NUM_SHADOW];

    assign we_v[IDX_CMP]  = cmp_we;
    assign we_v[IDX_ARR]  = arr_we;
    assign pre_v[IDX_CMP] = cmp_pre_en;
    assign pre_v[IDX_ARR] = arr_pre_en;
    assign wd_v[IDX_CMP]  = cmp_wdata;
    assign wd_v[IDX_ARR]  = arr_wdata;

    for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
        tpt_preload_reg #(.W(W)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .we     (we_v[g]),
            .wdata  (wd_v[g]),
            .pre_en (pre_v[g]),
            .uev    (uev),
            .act    (act_v[g])
        );
    end

    assign cmp_act = act_v[IDX_CMP];
    assign arr_act = act_v[IDX_ARR];

    tpt_count_ctrl #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .one_pulse (one_pulse),
        .sw_update (sw_update),
        .arr_act   (arr_act),
        .cnt       (cnt_out),
        .run       (running),
        .start     (start),
        .uev       (uev)
    );

    tpt_ref_gen #(.W(W)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .mode    (oc_mode),
        .cnt     (cnt_out),
        .cmp     (cmp_act),
        .arr     (arr_act),
        .start   (start),
        .uev     (uev),
        .fast_en (fast_en),
        .clr_en  (clr_en),
        .ext_clr (ext_clr),
        .ref_o   (ref_out)
    );

    assign wave_out = ref_out ^ out_pol;
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ext_clr,
    input logic         clr_en,
    input logic         one_pulse,
    input logic         sw_update,
    input logic         arr_pre_en,
    input logic [2:0]   oc_mode,
    input logic [W-1:0] cnt,
    input logic         running,
    input logic         ref_o,
    input logic [W-1:0] arr_act
);
    logic at_top;
    assign at_top = running && (cnt == arr_act);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (running && !at_top && !sw_update) |=> (running && cnt == W'($past(cnt) + 1)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!running && !sw_update) |=> (cnt == $past(cnt)));

    assert_rollover_R3: assert property (@(posedge clk) disable iff (rst)
        at_top |=> (cnt == '0));

    assert_opm_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (at_top && one_pulse) |=> !running);

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (running && !at_top && !sw_update) |=> running);

    assert_clear_low_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && ext_clr && oc_mode[2:1] == 2'b11) |=> (!ref_o || oc_mode[2:1] == 2'b10));

    assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
        (oc_mode == 3'b101) |-> ref_o);

    assert_force_low_R9: assert property (@(posedge clk) disable iff (rst)
        (oc_mode == 3'b100) |-> !ref_o);

    assert_arr_shadow_R10: assert property (@(posedge clk) disable iff (rst)
        (arr_pre_en && !sw_update && !at_top) |=> (arr_act == $past(arr_act)));

    assert_sw_update_R11: assert property (@(posedge clk) disable iff (rst)
        sw_update |=> (cnt == '0));
endmodule

bind trig_pulse_timer tpt_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_clr    (ext_clr),
    .clr_en     (clr_en),
    .one_pulse  (one_pulse),
    .sw_update  (sw_update),
    .arr_pre_en (arr_pre_en),
    .oc_mode    (oc_mode),
    .cnt        (cnt_out),
    .running    (running),
    .ref_o      (ref_out),
    .arr_act    (arr_act)
);

// File: tb/trig_pulse_timer_bench.sv
module trig_pulse_timer_bench;
    localparam int W   = 8;
    localparam int MOD = 1 << W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         trig_in = 0, ext_clr = 0, one_pulse = 0, fast_en = 0, clr_en = 0;
    logic         cmp_pre_en = 0, arr_pre_en = 0, cmp_we = 0, arr_we = 0;
    logic         sw_update = 0, out_pol = 0;
    logic [2:0]   oc_mode = 3'b111;
    logic [W-1:0] cmp_wdata = '0, arr_wdata = '0;
    logic [W-1:0] cnt_out;
    logic         running, ref_out, wave_out;

    trig_pulse_timer #(.W(W)) u_trig_pulse_timer (
        .clk(clk), .rst(rst), .trig_in(trig_in), .ext_clr(ext_clr), .oc_mode(oc_mode),
        .one_pulse(one_pulse), .fast_en(fast_en), .clr_en(clr_en),
        .cmp_pre_en(cmp_pre_en), .arr_pre_en(arr_pre_en), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .arr_we(arr_we), .arr_wdata(arr_wdata),
        .sw_update(sw_update), .out_pol(out_pol), .cnt_out(cnt_out),
        .running(running), .ref_out(ref_out), .wave_out(wave_out)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt = 0, m_cmp = 0, m_arr = 0, m_cmp_sh = 0, m_arr_sh = 0;
    bit m_run = 0, m_tq = 0, m_fast = 0, m_clr = 0;

    function automatic bit model_ref();
        bit forced_m = (oc_mode == 3'b100) || (oc_mode == 3'b101);
        bit r;
        case (oc_mode)
            3'b100: r = 0;
            3'b101: r = 1;
            3'b110: r = m_fast ? 0 : (m_cnt < m_cmp);
            3'b111: r = m_fast ? (m_cnt != m_arr) : ((m_cnt >= m_cmp) && (m_cnt != m_arr));
            default: r = 0;
        endcase
        if (m_clr && !forced_m) r = 0;
        return r;
    endfunction

    always @(posedge clk) begin : model
        bit st, ue, frc, pw;
        int old_cmp_sh, old_arr_sh;
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_arr = 0; m_cmp_sh = 0; m_arr_sh = 0;
            m_run = 0; m_tq = 0; m_fast = 0; m_clr = 0;
        end else begin
            st  = trig_in && !m_tq && !m_run;
            ue  = sw_update || (m_run && m_cnt == m_arr);
            frc = (oc_mode == 3'b100) || (oc_mode == 3'b101);
            pw  = oc_mode[2:1] == 2'b11;
            if (st && fast_en && pw) m_fast = 1; else if (ue) m_fast = 0;
            if (clr_en && ext_clr && !frc) m_clr = 1; else if (ue) m_clr = 0;
            if (ue) m_cnt = 0; else if (m_run) m_cnt = (m_cnt + 1) % MOD;
            if (st) m_run = 1; else if (ue && one_pulse) m_run = 0;
            old_cmp_sh = m_cmp_sh;
            old_arr_sh = m_arr_sh;
            if (cmp_we) m_cmp_sh = cmp_wdata;
            if (arr_we) m_arr_sh = arr_wdata;
            if (cmp_we && !cmp_pre_en) m_cmp = cmp_wdata; else if (ue) m_cmp = old_cmp_sh;
            if (arr_we && !arr_pre_en) m_arr = arr_wdata; else if (ue) m_arr = old_arr_sh;
            m_tq = trig_in;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk("R2 count vs model", cnt_out, m_cnt);
            chk("R3 running vs model", running, m_run);
            chk("R4 ref vs model", ref_out, model_ref());
            chk("R12 wave vs model", wave_out, model_ref() ^ out_pol);
        end
    end

    task automatic wr(input bit to_arr, input int v);
        @(negedge clk);
        if (to_arr) begin arr_we = 1; arr_wdata = W'(v); end
        else begin cmp_we = 1; cmp_wdata = W'(v); end
        @(negedge clk);
        arr_we = 0; cmp_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic swu();
        @(negedge clk); sw_update = 1;
        @(negedge clk); sw_update = 0;
    endtask

    // one trigger; returns first running index, first ref index,
    // ref-high cycles while running, running cycles
    task automatic pulse(input int ncyc, input int retrig_at, input int clr_at,
                         input int swu_at, output int run_first, output int ref_first,
                         output int ref_high, output int run_high);
        run_first = -1; ref_first = -1; ref_high = 0; run_high = 0;
        @(negedge clk); trig_in = 1;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (running && run_first < 0) run_first = i;
            if (ref_out && ref_first < 0) ref_first = i;
            if (running) begin
                run_high++;
                if (ref_out) ref_high++;
            end
            trig_in   = (i == retrig_at);
            ext_clr   = (i == clr_at);
            sw_update = (i == swu_at);
        end
        trig_in = 0; ext_clr = 0; sw_update = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int rf, pf, ph, rh;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset count", cnt_out, 0);
        chk("R1 reset running", running, 0);
        chk("R1 reset ref", ref_out, 0);

        // basic one-shot, no preload
        one_pulse = 1;
        wr(0, 3); wr(1, 7);
        pulse(12, 0, 0, 0, rf, pf, ph, rh);
        chk("R2 running rises one clock after edge", rf, 1);
        chk("R5 delay", pf - rf, 3);
        chk("R5 width", ph, 4);
        chk("R5 run length", rh, 8);
        chk("R3 stopped after one pulse", running, 0);
        chk("R3 count back at 0", cnt_out, 0);

        // retrigger during the pulse
        pulse(12, 3, 0, 0, rf, pf, ph, rh);
        chk("R6 run length with retrigger", rh, 8);
        chk("R6 width with retrigger", ph, 4);
        idle(3);
        chk("R6 no restart", running, 0);

        // PWM1
        oc_mode = 3'b110;
        pulse(12, 0, 0, 0, rf, pf, ph, rh);
        chk("R4 PWM1 high cycles", ph, 3);
        oc_mode = 3'b111;

        // fast start
        fast_en = 1;
        wr(0, 5); wr(1, 9);
        pulse(14, 0, 0, 0, rf, pf, ph, rh);
        chk("R7 fast ref at start", pf, 1);
        chk("R7 fast width", ph, 9);
        fast_en = 0;

        // external clear pulse ending early
        clr_en = 1;
        wr(0, 2);
        pulse(14, 0, 4, 0, rf, pf, ph, rh);
        chk("R8 cleared width", ph, 2);
        chk("R8 ref first", pf, 3);
        pulse(14, 0, 0, 0, rf, pf, ph, rh);
        chk("R8 clear released at update", ph, 7);

        // forced modes with clear held high
        oc_mode = 3'b101; ext_clr = 1;
        idle(2);
        chk("R9 force high with clear", ref_out, 1);
        oc_mode = 3'b100;
        idle(2);
        chk("R9 force low", ref_out, 0);
        ext_clr = 0; oc_mode = 3'b101;
        pulse(14, 0, 0, 0, rf, pf, ph, rh);
        chk("R9 force high while counting", ph, 10);
        oc_mode = 3'b000;
        idle(1);
        chk("R9 other encoding low", ref_out, 0);
        oc_mode = 3'b111; clr_en = 0;
        idle(1);
        chk("R8 clear never latched in forced mode", ref_out, 0);

        // preload via natural rollover
        cmp_pre_en = 1; arr_pre_en = 1;
        wr(0, 1); wr(1, 4);
        pulse(14, 0, 0, 0, rf, pf, ph, rh);
        chk("R10 old reload in use", rh, 10);
        chk("R10 old compare in use", ph, 7);
        pulse(10, 0, 0, 0, rf, pf, ph, rh);
        chk("R10 new reload after update", rh, 5);
        chk("R10 new compare after update", ph, 3);

        // preload via software update
        wr(0, 2); wr(1, 6);
        swu();
        idle(1);
        chk("R11 count zero after sw update", cnt_out, 0);
        pulse(12, 0, 0, 0, rf, pf, ph, rh);
        chk("R11 reload moved by sw update", rh, 7);
        chk("R11 compare moved by sw update", ph, 4);

        // sw update mid-pulse stops one-shot
        pulse(6, 0, 0, 3, rf, pf, ph, rh);
        chk("R11 stop by sw update", rh, 3);
        chk("R11 running low", running, 0);

        // preload off: immediate write
        cmp_pre_en = 0; arr_pre_en = 0;
        wr(0, 3); wr(1, 7);
        pulse(12, 0, 0, 0, rf, pf, ph, rh);
        chk("R10 immediate write", ph, 4);

        // free-running PWM
        one_pulse = 0;
        pulse(20, 0, 0, 0, rf, pf, ph, rh);
        chk("R3 free-running run length", rh, 20);
        chk("R4 free-running high cycles", ph, 9);
        one_pulse = 1;
        idle(10);
        chk("R3 stop at next update", running, 0);

        // polarity
        out_pol = 1;
        idle(1);
        chk("R12 inverted idle", wave_out, 1);
        out_pol = 0;
        idle(1);
        chk("R12 plain idle", wave_out, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule